// File: doc/BRIEF.md
# Link Port Receiver with Acknowledge Flow Control

This block is the receive side of a point-to-point link. The sender forwards its own clock and pulses it once per transfer unit. Each unit is a 4-bit nibble or an 8-bit byte on the link data lanes. The receiver samples the lanes on each falling edge of that clock and packs the units into a 32-bit or 48-bit word. A finished word is handed to the core clock domain, where it enters a two-entry receive buffer.

The receiver throttles the sender through an acknowledge output. The sender checks that line before it starts each word. Acknowledge is held low while the buffer cannot take another word. In the 48-bit fast mode it also drops after every completed word until that word has landed. The core takes words through a simple read port. A read issued while the buffer is empty is held with a stall indication until a word arrives. A ready flag tells the core that at least one word is waiting.

Configuration inputs (lane width, word size, fast mode) are quasi-static. The forwarded clock is assumed to be no faster than the core clock, and each unit spans at least two core cycles.

Top module: `lp_rx`

## Requirements
- R1: While `en_i` is high, the lanes are sampled on each falling edge of `lclk_i`. Units fill the word from bit 0 upward, so the first unit of a word lands in its least significant bits.
- R2: With `wide_i`=1 a unit is `ldat_i[7:0]`. With `wide_i`=0 a unit is `ldat_i[3:0]` and `ldat_i[7:4]` is ignored.
- R2 (word size): `long_i`=1 selects a 48-bit word (12 nibbles or 6 bytes). `long_i`=0 selects a 32-bit word (8 nibbles or 4 bytes), and `rd_data_o[47:32]` then reads as zero.
- R3: `lack_o` is low whenever the buffer holds two words, and the buffer never holds more than two.
- R4: `rd_stall_o` is high while `rd_req_i` is high and the buffer is empty. The held read completes at the first clock edge at which a word is present, and it returns that word.
- R5: `rx_ready_o` is high exactly when the buffer holds at least one word.
- R6: When a read frees an entry of a full buffer, `lack_o` rises at the next rising clock edge, provided `en_i` is high and no word is in transit.
- R7: With `fast_i`=1 and `long_i`=1, `lack_o` falls at the falling edge that completes a word and stays low until that word is in the buffer. In the other modes, a word completing into an empty buffer leaves `lack_o` high.
- R8: Taking `en_i` low discards any partly assembled word and forces `lack_o` low from the next rising clock edge. After re-enable, the next word is assembled from its first unit.
- R9: A completed word enters the buffer at the third rising `clk` edge after the falling `lclk_i` edge that completed it. This delay covers the two-stage synchroniser and the edge detector.
- R10: Words are read out in the order in which they were completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset; synchronous in the core domain, asynchronous in the link domain |
| en_i | input | 1 | Port enable; low clears a partial word and holds acknowledge low |
| wide_i | input | 1 | 1: 8-bit lanes, 0: 4-bit lanes |
| long_i | input | 1 | 1: 48-bit words, 0: 32-bit words |
| fast_i | input | 1 | Fastest link rate; with long words, acknowledge drops after every word |
| lclk_i | input | 1 | Forwarded link clock from the sender |
| ldat_i | input | 8 | Link data lanes |
| lack_o | output | 1 | Acknowledge to the sender; high means another word may be started |
| rd_req_i | input | 1 | Core read request |
| rd_data_o | output | 48 | Word at the head of the buffer |
| rd_stall_o | output | 1 | Read held because the buffer is empty |
| rx_ready_o | output | 1 | Buffer not empty |

## Verification
Results fall due at the following times:
- A completed word shows on `rx_ready_o` after the third rising clock edge that follows its last falling link-clock edge. The bench samples on falling core-clock edges: once after the second rising edge, expecting no word yet, and once after the third.
- The fast-mode acknowledge drop is combinational from the link-side toggle. It is checked 1 ns after the completing edge.
- The acknowledge rise after a read comes one rising edge after the pop. The bench samples it two falling edges later.
- The full-buffer and disable cases are checked only after several cycles, once every register on the path has settled.

All eight combinations of lane width, word size and fast mode are swept with computed word patterns.

// File: rtl/lp_rx_pkg.sv
// Shared constants, the word type and the unit-count helper for the link
// receiver. Assumes lanes are two nibbles wide and word sizes are nibble multiples.
package lp_rx_pkg;
    localparam int NIB_W    = 4;
    localparam int LANE_W   = 2 * NIB_W;
    localparam int LONG_W   = 48;
    localparam int SHORT_W  = 32;
    localparam int NIB_LONG = LONG_W / NIB_W;
    localparam int CNT_W    = $clog2(NIB_LONG);

    typedef logic [LONG_W-1:0] word_t;

    // Index of the final unit of a word for the given lane width and word size.
    function automatic logic [CNT_W-1:0] last_unit(input logic wide, input logic long_w);
        int bits;
        int units;
        bits  = long_w ? LONG_W : SHORT_W;
        units = bits / (wide ? LANE_W : NIB_W);
        return CNT_W'(units - 1);
    endfunction
endpackage

// File: rtl/lp_rx_assembler.sv
// Link-clock-domain unit packer. Samples the lanes on each falling edge of the
// forwarded clock and builds a word from bit 0 upward. On the final unit it
// latches the word into a holding register and toggles a request bit.
// Assumes the holding register is read by the core before the next word
// completes (at least four units of two core cycles each).
module lp_rx_assembler
    import lp_rx_pkg::*;
(
    input  logic              lclk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              wide_i,
    input  logic              long_i,
    input  logic [LANE_W-1:0] ldat_i,
    output word_t             hold_o,
    output logic              req_o
);
    logic [CNT_W-1:0] idx_q;
    word_t            acc_q;
    word_t            acc_nx;
    word_t            hold_q;
    logic             req_q;
    logic             done;
    logic             arm_n;

    assign arm_n = rst_n & en_i;
    assign done  = (idx_q == last_unit(wide_i, long_i));

    // Place the current unit into its nibble slots of the word under assembly.
    always_comb begin
        acc_nx = acc_q;
        for (int p = 0; p < NIB_LONG; p++) begin
            if (wide_i) begin
                if ((p / 2) == int'(idx_q))
                    acc_nx[p*NIB_W +: NIB_W] = (p % 2 == 1) ? ldat_i[LANE_W-1:NIB_W]
                                                            : ldat_i[NIB_W-1:0];
            end else if (p == int'(idx_q)) begin
                acc_nx[p*NIB_W +: NIB_W] = ldat_i[NIB_W-1:0];
            end
        end
    end

    // Unit counter and partial word; cleared at once by reset or disable.
    always_ff @(negedge lclk or negedge arm_n) begin
        if (!arm_n) begin
            idx_q <= '0;
            acc_q <= '0;
        end else if (done) begin
            idx_q <= '0;
            acc_q <= '0;
        end else begin
            idx_q <= idx_q + 1'b1;
            acc_q <= acc_nx;
        end
    end

    // Hand a completed word over: latch it and toggle the request.
    always_ff @(negedge lclk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
            req_q  <= 1'b0;
        end else if (en_i && done) begin
            hold_q <= acc_nx;
            req_q  <= ~req_q;
        end
    end

    assign hold_o = hold_q;
    assign req_o  = req_q;
endmodule

// File: rtl/lp_rx_sync.sv
// Multi-flop synchroniser for a single level or toggle bit into the core clock.
// Assumes STAGES >= 2.
module lp_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] sh_q;

    // Shift the asynchronous bit through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[STAGES-2:0], d_i};
    end

    assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/lp_rx_buffer.sv
// Core-domain receive buffer of DEPTH words, with fill count and registered
// flow hints. A push into a full buffer or a pop from an empty one is refused.
// room_o and last_slot_o reflect the fill after the current edge.
module lp_rx_buffer
    import lp_rx_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       en_i,
    input  logic                       push_i,
    input  word_t                      push_data_i,
    input  logic                       pop_i,
    output word_t                      head_o,
    output logic [$clog2(DEPTH+1)-1:0] fill_o,
    output logic                       room_o,
    output logic                       last_slot_o
);
    localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int FILL_W = $clog2(DEPTH + 1);

    word_t             slot_q [DEPTH];
    logic [PTR_W-1:0]  wr_q;
    logic [PTR_W-1:0]  rd_q;
    logic [FILL_W-1:0] fill_q;
    logic [FILL_W-1:0] fill_nx;
    logic              accept;
    logic              take;
    logic              room_q;
    logic              last_q;

    assign accept = push_i && (fill_q != FILL_W'(DEPTH));
    assign take   = pop_i && (fill_q != '0);

    // Next fill level from the accepted push and pop.
    always_comb begin
        fill_nx = fill_q;
        if (accept && !take)      fill_nx = fill_q + 1'b1;
        else if (take && !accept) fill_nx = fill_q - 1'b1;
    end

    // Write the incoming word into its slot.
    always_ff @(posedge clk) begin
        if (accept) slot_q[wr_q] <= push_data_i;
    end

    // Pointers, fill level and flow hints.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q   <= '0;
            rd_q   <= '0;
            fill_q <= '0;
            room_q <= 1'b0;
            last_q <= 1'b0;
        end else begin
            if (accept) wr_q <= (wr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
            if (take)   rd_q <= (rd_q == PTR_W'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
            fill_q <= fill_nx;
            room_q <= en_i && (fill_nx < FILL_W'(DEPTH));
            last_q <= (fill_nx == FILL_W'(DEPTH - 1));
        end
    end

    assign head_o      = slot_q[rd_q];
    assign fill_o      = fill_q;
    assign room_o      = room_q;
    assign last_slot_o = last_q;
endmodule

// File: rtl/lp_rx.sv
// Link port receiver top. Joins the link-domain packer, the request
// synchroniser, the receive buffer and the acknowledge logic.
// Assumes quasi-static configuration inputs and a forwarded clock no faster
// than the core clock.
module lp_rx
    import lp_rx_pkg::*;
#(
    parameter int DEPTH       = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              wide_i,
    input  logic              long_i,
    input  logic              fast_i,
    input  logic              lclk_i,
    input  logic [LANE_W-1:0] ldat_i,
    output logic              lack_o,
    input  logic              rd_req_i,
    output logic [LONG_W-1:0] rd_data_o,
    output logic              rd_stall_o,
    output logic              rx_ready_o
);
    localparam int FILL_W = $clog2(DEPTH + 1);

    word_t             hold_w;
    logic              req_l;
    logic              req_s;
    logic              req_seen_q;
    logic              push_w;
    logic              pop_w;
    logic [FILL_W-1:0] fill_w;
    logic              room_w;
    logic              last_slot_w;
    logic              in_flight_w;
    logic              empty_w;

    lp_rx_assembler u_asm (
        .lclk   (lclk_i),
        .rst_n  (rst_n),
        .en_i   (en_i),
        .wide_i (wide_i),
        .long_i (long_i),
        .ldat_i (ldat_i),
        .hold_o (hold_w),
        .req_o  (req_l)
    );

    lp_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (req_l),
        .q_o   (req_s)
    );

    // Remember the last synchronised request; this also serves as the returned acknowledge toggle.
    always_ff @(posedge clk) begin
        if (!rst_n) req_seen_q <= 1'b0;
        else        req_seen_q <= req_s;
    end

    assign push_w      = req_s ^ req_seen_q;
    assign in_flight_w = req_l ^ req_seen_q;
    assign empty_w     = (fill_w == '0);
    assign pop_w       = rd_req_i && !empty_w;

    lp_rx_buffer #(.DEPTH(DEPTH)) u_buf (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_i        (en_i),
        .push_i      (push_w),
        .push_data_i (hold_w),
        .pop_i       (pop_w),
        .head_o      (rd_data_o),
        .fill_o      (fill_w),
        .room_o      (room_w),
        .last_slot_o (last_slot_w)
    );

    // Hold the sender while a word in transit will take the last slot, or after every word in fast long mode.
    assign lack_o     = room_w && !(in_flight_w && ((fast_i && long_i) || last_slot_w));
    assign rd_stall_o = rd_req_i && empty_w;
    assign rx_ready_o = !empty_w;
endmodule

// File: rtl/lp_rx_checker.sv
// Property checker for lp_rx, attached to every instance by bind.
module lp_rx_checker #(
    parameter int DEPTH = 2
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       en_i,
    input logic                       lack_o,
    input logic                       rd_req_i,
    input logic                       rd_stall_o,
    input logic                       rx_ready_o,
    input logic                       push_i,
    input logic [$clog2(DEPTH+1)-1:0] fill_i
);
    p_full_holds_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(fill_i) == DEPTH) |-> !lack_o)
        else $error("full buffer with acknowledge high");

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> (int'(fill_i) != DEPTH))
        else $error("word arrived at a full buffer");

    p_fill_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (int'(fill_i) <= DEPTH) &&
                 ((fill_i == $past(fill_i)) || (int'(fill_i) == int'($past(fill_i)) + 1) ||
                  (int'(fill_i) + 1 == int'($past(fill_i)))))
        else $error("fill level jumped");

    p_empty_stalls_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_i && fill_i == '0) |-> rd_stall_o)
        else $error("empty read not stalled");

    p_read_needs_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_i && !rd_stall_o) |-> rx_ready_o)
        else $error("read completed without ready flag");

    p_disabled_no_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !lack_o)
        else $error("acknowledge high while disabled");
endmodule

bind lp_rx lp_rx_checker #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_i       (en_i),
    .lack_o     (lack_o),
    .rd_req_i   (rd_req_i),
    .rd_stall_o (rd_stall_o),
    .rx_ready_o (rx_ready_o),
    .push_i     (push_w),
    .fill_i     (fill_w)
);

// File: tb/sim_lp_rx.sv
// Self-checking bench for lp_rx: sweeps every lane/word/fast combination.
module sim_lp_rx;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0, wide = 1'b0, lng = 1'b0, fast = 1'b0;
    logic        lclk = 1'b0;
    logic [7:0]  ldat = '0;
    logic        rd_req = 1'b0;
    logic        lack, rd_stall, rx_ready;
    logic [47:0] rd_data;
    int          n_run = 0, n_fail = 0;

    lp_rx u0 (
        .clk(clk), .rst_n(rst_n), .en_i(en), .wide_i(wide), .long_i(lng), .fast_i(fast),
        .lclk_i(lclk), .ldat_i(ldat), .lack_o(lack), .rd_req_i(rd_req),
        .rd_data_o(rd_data), .rd_stall_o(rd_stall), .rx_ready_o(rx_ready)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string tag, input logic [47:0] act, input logic [47:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [47:0] pat(input int k, input bit l);
        logic [47:0] w;
        w = (48'h1F3B_5D79_A2C4 * 48'(k + 3)) ^ {8'(k), 40'h0} ^ 48'(k);
        return l ? w : {16'h0, w[31:0]};
    endfunction

    // Drive n units of w, one per falling edge of lclk (two core cycles per unit).
    task automatic send_units(input logic [47:0] w, input bit wd, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (wd) ldat = w[i*8 +: 8];
            else    ldat = {~w[i*4 +: 4], w[i*4 +: 4]};
            lclk = 1'b1;
            @(negedge clk);
            lclk = 1'b0;
        end
    endtask

    task automatic send_word(input logic [47:0] w, input bit wd, input bit l);
        send_units(w, wd, (l ? 48 : 32) / (wd ? 8 : 4));
    endtask

    task automatic wait_ack();
        int t = 0;
        while (!lack && t < 1000) begin
            @(negedge clk);
            t++;
        end
    endtask

    task automatic read_word(output logic [47:0] d);
        @(negedge clk);
        rd_req = 1'b1;
        #1;
        while (rd_stall) begin
            @(negedge clk);
            #1;
        end
        d = rd_data;
        @(negedge clk);
        rd_req = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog expired actual=%h expected=%h", 48'h0, 48'h1);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [47:0] got, a, b;
        int k = 0;
        idle(4);
        check(lack == 1'b0, "R8 reset ack low", 48'(lack), 48'h0);
        check(rx_ready == 1'b0, "R5 reset not ready", 48'(rx_ready), 48'h0);
        rst_n = 1'b1;
        idle(2);
        check(lack == 1'b0, "R8 disabled ack low", 48'(lack), 48'h0);
        en = 1'b1;
        idle(2);
        check(lack == 1'b1, "R6 ack high when enabled and empty", 48'(lack), 48'h1);

        // Sweep every configuration.
        for (int cfg = 0; cfg < 8; cfg++) begin
            wide = cfg[0];
            lng  = cfg[1];
            fast = cfg[2];
            a = pat(k, lng);
            b = pat(k + 1, lng);
            k += 2;
            check(rx_ready == 1'b0, "R5 empty before word", 48'(rx_ready), 48'h0);
            wait_ack();
            send_word(a, wide, lng);
            #1;
            if (fast && lng) check(lack == 1'b0, "R7 ack drops after word", 48'(lack), 48'h0);
            else             check(lack == 1'b1, "R7 ack stays high", 48'(lack), 48'h1);
            @(posedge clk);
            @(posedge clk);
            @(negedge clk);
            check(rx_ready == 1'b0, "R9 not yet after two edges", 48'(rx_ready), 48'h0);
            @(posedge clk);
            @(negedge clk);
            check(rx_ready == 1'b1, "R9 R5 ready after third edge", 48'(rx_ready), 48'h1);
            idle(3);
            check(lack == 1'b1, "R7 ack back once written", 48'(lack), 48'h1);
            wait_ack();
            send_word(b, wide, lng);
            idle(6);
            check(lack == 1'b0, "R3 full holds ack", 48'(lack), 48'h0);
            read_word(got);
            check(got == a, "R1 R2 R10 first word", got, a);
            idle(2);
            check(lack == 1'b1, "R6 ack after read", 48'(lack), 48'h1);
            read_word(got);
            check(got == b, "R1 R2 R10 second word", got, b);
            idle(1);
            check(rx_ready == 1'b0, "R5 empty after reads", 48'(rx_ready), 48'h0);
        end

        // Stalled read completes when a word arrives.
        wide = 1'b0;
        lng  = 1'b0;
        fast = 1'b0;
        a = pat(50, 1'b0);
        @(negedge clk);
        rd_req = 1'b1;
        #1;
        check(rd_stall == 1'b1, "R4 stall on empty read", 48'(rd_stall), 48'h1);
        fork
            send_word(a, 1'b0, 1'b0);
            begin
                int t = 0;
                while (rd_stall && t < 500) begin
                    @(negedge clk);
                    #1;
                    t++;
                end
                got = rd_data;
            end
        join
        @(negedge clk);
        rd_req = 1'b0;
        check(got == a, "R4 stalled read returns word", got, a);
        idle(2);
        check(rx_ready == 1'b0, "R4 stalled read popped word", 48'(rx_ready), 48'h0);

        // Disable in the middle of a word discards the partial word.
        wide = 1'b1;
        lng  = 1'b1;
        a = pat(60, 1'b1);
        b = pat(61, 1'b1);
        send_units(a, 1'b1, 3);
        @(negedge clk);
        en = 1'b0;
        idle(2);
        check(lack == 1'b0, "R8 ack low when disabled", 48'(lack), 48'h0);
        idle(4);
        check(rx_ready == 1'b0, "R8 partial word not stored", 48'(rx_ready), 48'h0);
        en = 1'b1;
        idle(2);
        wait_ack();
        send_word(b, 1'b1, 1'b1);
        read_word(got);
        check(got == b, "R8 fresh word after re-enable", got, b);

        // Lanes [7:4] ignored in 4-bit mode: upper lane carries inverted data.
        wide = 1'b0;
        lng  = 1'b1;
        a = pat(70, 1'b1);
        wait_ack();
        send_word(a, 1'b0, 1'b1);
        read_word(got);
        check(got == a, "R2 upper lanes ignored in narrow mode", got, a);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule